// File: doc/BRIEF.md
# Reset Cause and Soft-Reset Control Register

This block is a single 32-bit register that a system reset controller exposes to software. It records why the machine last went through reset, and it lets software start a full soft reset that behaves like a power-on reset, or a lighter soft reset that behaves like an externally initiated one. The five implemented bits sit at the top of the word. The three hardware cause bits are cleared by writing a one. The two soft-reset command bits are set by writing a one and stay set until the next reset that reloads the register. Every write that sets a command bit sends a one-cycle request to the system reset sequencer.

The block separates the first system reset after power-up from every later one. A two-state arming machine holds this information. In `ARM_COLD` the next system reset counts as power-on: the register is loaded with the power-on cause alone, and the machine takes transition `T_FIRST_RESET` to `ARM_WARM`. In `ARM_WARM` a system reset leaves the register as it is. The only thing added is the button cause bits that arrive with that reset. A soft power-on write takes transition `T_REARM` from `ARM_WARM` back to `ARM_COLD`, so the reset it requests is treated as a power-on reset. The power-up reset `por_n` puts the machine in `ARM_COLD` and clears the register. The sequencer is expected to follow it with a system reset pulse.

Top module: `reset_cause_ctl`

## Requirements
- R1: While `por_n` is low, and right after it is released, `rd_data` is 0x00000000 and `rst_req` is 0.
- R2: The first `sys_rst` after power-up loads `rd_data` with exactly bit 31 set (0x80000000), apart from any button cause bits that arrive with the same reset.
- R3: A `sys_rst` in the warm state leaves every register bit unchanged. It only ORs in bit 28 when `btn_por_cause` is 1 and bit 27 when `btn_xir_cause` is 1.
- R4: Bits 26 down to 0 always read as zero, whatever value was written.
- R5: Writing 1 to bit 31 (power-on cause), bit 28 (button power-on cause) or bit 27 (button external cause) clears that bit. Writing 0 to those bits leaves them unchanged.
- R6: Writing 1 to bit 30 (soft power-on command) or bit 29 (soft external command) sets that bit. Writing 0 to those bits does not clear them.
- R7: A write with bit 30 or bit 29 set drives `rst_req` high for exactly the one cycle after the write is accepted. Writes on consecutive cycles give consecutive request cycles.
- R8: A write with bit 30 set re-arms the block, so the next `sys_rst` loads 0x80000000 as in R2. A write with only bit 29 set does not re-arm it.
- R9: A write in the same cycle as `sys_rst` is ignored. It changes no bit, raises no request and does not re-arm the block.
- R10: A write with both bit 30 and bit 29 clear raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-up reset, active low |
| sys_rst | input | 1 | One-cycle system reset event from the sequencer |
| btn_por_cause | input | 1 | The current system reset came from the power-on button |
| btn_xir_cause | input | 1 | The current system reset came from the external-reset button |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Current register value |
| rst_req | output | 1 | One-cycle request to the reset sequencer |

## Verification
The bench checks that writing zero to a command bit does not clear it. A design that treated the command bits as plain loads would drop a pending soft-reset indication there. It checks that only a soft power-on write re-arms the block. Getting this wrong would either reload 0x80000000 after a soft external reset or keep stale bits after a soft power-on. The collision of a write with a system reset is checked, because a design that lets the write through issues a spurious request that outlives the reset. Back-to-back command writes and a write of all ones are also covered: the first needs one request per write, and the second must clear the three cause bits, set both command bits and leave the low bits at zero.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
    localparam int WORD_W       = 32;
    localparam int POR_BIT      = 31;
    localparam int SOFT_POR_BIT = 30;
    localparam int SOFT_XIR_BIT = 29;
    localparam int BTN_POR_BIT  = 28;
    localparam int BTN_XIR_BIT  = 27;

    localparam logic [WORD_W-1:0] ONE_W = {{(WORD_W-1){1'b0}}, 1'b1};

    // bits cleared by writing one (hardware causes)
    localparam logic [WORD_W-1:0] CLR_MASK =
        (ONE_W << POR_BIT) | (ONE_W << BTN_POR_BIT) | (ONE_W << BTN_XIR_BIT);
    // bits set by writing one (soft commands)
    localparam logic [WORD_W-1:0] SET_MASK =
        (ONE_W << SOFT_POR_BIT) | (ONE_W << SOFT_XIR_BIT);
    localparam logic [WORD_W-1:0] IMPL_MASK = CLR_MASK | SET_MASK;
    localparam logic [WORD_W-1:0] POR_VALUE = ONE_W << POR_BIT;

    typedef enum logic [0:0] {
        ARM_COLD = 1'b0,
        ARM_WARM = 1'b1
    } arm_state_e;
endpackage

// File: rtl/rstc_arm_fsm.sv
module rstc_arm_fsm
    import rstc_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic sys_rst,
    input  logic rearm,
    output logic armed
);
    arm_state_e state_q;
    arm_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARM_COLD: if (sys_rst) state_d = ARM_WARM;        // T_FIRST_RESET
            ARM_WARM: if (!sys_rst && rearm) state_d = ARM_COLD; // T_REARM
            default:  state_d = ARM_COLD;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= ARM_COLD;
        else        state_q <= state_d;
    end

    always_comb begin
        armed = (state_q == ARM_COLD);
    end
endmodule

// File: rtl/rstc_cause_reg.sv
module rstc_cause_reg
    import rstc_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst,
    input  logic              armed,
    input  logic              btn_por_cause,
    input  logic              btn_xir_cause,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] value,
    output logic              req_pulse
);
    logic [WORD_W-1:0] val_q;
    logic [WORD_W-1:0] val_d;
    logic [WORD_W-1:0] wv;
    logic [WORD_W-1:0] btn_bits;
    logic              req_d;
    logic              req_q;

    always_comb begin
        wv       = wr_data & IMPL_MASK;
        btn_bits = ({{(WORD_W-1){1'b0}}, btn_por_cause} << BTN_POR_BIT)
                 | ({{(WORD_W-1){1'b0}}, btn_xir_cause} << BTN_XIR_BIT);
        if (sys_rst) begin
            val_d = (armed ? POR_VALUE : val_q) | btn_bits;
        end else if (wr_en) begin
            val_d = (val_q & ~(wv & CLR_MASK)) | (wv & SET_MASK);
        end else begin
            val_d = val_q;
        end
        req_d = wr_en && !sys_rst && (|(wv & SET_MASK));
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            val_q <= '0;
            req_q <= 1'b0;
        end else begin
            val_q <= val_d;
            req_q <= req_d;
        end
    end

    assign value     = val_q;
    assign req_pulse = req_q;
endmodule

// File: rtl/reset_cause_ctl.sv
module reset_cause_ctl
    import rstc_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst,
    input  logic              btn_por_cause,
    input  logic              btn_xir_cause,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic              rst_req
);
    logic armed;
    logic rearm;

    assign rearm = wr_en && wr_data[SOFT_POR_BIT];

    rstc_arm_fsm u_arm (
        .clk     (clk),
        .por_n   (por_n),
        .sys_rst (sys_rst),
        .rearm   (rearm),
        .armed   (armed)
    );

    rstc_cause_reg u_reg (
        .clk           (clk),
        .por_n         (por_n),
        .sys_rst       (sys_rst),
        .armed         (armed),
        .btn_por_cause (btn_por_cause),
        .btn_xir_cause (btn_xir_cause),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .value         (rd_data),
        .req_pulse     (rst_req)
    );
endmodule

// File: rtl/rstc_checker.sv
module rstc_checker
    import rstc_pkg::*;
(
    input logic              clk,
    input logic              por_n,
    input logic              sys_rst,
    input logic              wr_en,
    input logic [WORD_W-1:0] wr_data,
    input logic [WORD_W-1:0] rd_data,
    input logic              rst_req
);
    a_r4_low_bits_zero: assert property (@(posedge clk) disable iff (!por_n)
        rd_data[BTN_XIR_BIT-1:0] == '0);

    a_r7_req_from_cmd_write: assert property (@(posedge clk) disable iff (!por_n)
        rst_req |-> $past(wr_en && !sys_rst &&
                          (wr_data[SOFT_POR_BIT] || wr_data[SOFT_XIR_BIT])));

    a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!por_n)
        (!sys_rst && !wr_en) |=> $stable(rd_data));

    a_r6_cmd_sticky: assert property (@(posedge clk) disable iff (!por_n)
        (rd_data[SOFT_XIR_BIT] && !sys_rst) |=> rd_data[SOFT_XIR_BIT]);

    a_r8_rearmed_reload: assert property (@(posedge clk) disable iff (!por_n)
        (sys_rst && rd_data[SOFT_POR_BIT]) |=> (rd_data[POR_BIT:SOFT_XIR_BIT] == 3'b100));

    a_r9_collision_no_req: assert property (@(posedge clk) disable iff (!por_n)
        sys_rst |=> !rst_req);
endmodule

bind reset_cause_ctl rstc_checker u_rstc_checker (
    .clk     (clk),
    .por_n   (por_n),
    .sys_rst (sys_rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .rst_req (rst_req)
);

// File: tb/test_reset_cause_ctl.sv
module test_reset_cause_ctl;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        sys_rst = 1'b0;
    logic        btn_por_cause = 1'b0;
    logic        btn_xir_cause = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        rst_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    reset_cause_ctl i_reset_cause_ctl (
        .clk           (clk),
        .por_n         (por_n),
        .sys_rst       (sys_rst),
        .btn_por_cause (btn_por_cause),
        .btn_xir_cause (btn_xir_cause),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .rd_data       (rd_data),
        .rst_req       (rst_req)
    );

    // {sys_rst, btn_por, btn_xir, wr_en, wr_data, expected rd_data, expected rst_req}
    localparam int NV = 20;
    localparam logic [68:0] VEC [NV] = '{
        {4'b1000, 32'h0000_0000, 32'h8000_0000, 1'b0}, // R2 first reset
        {4'b0001, 32'h0000_0000, 32'h8000_0000, 1'b0}, // R10 no command
        {4'b0001, 32'h07FF_FFFF, 32'h8000_0000, 1'b0}, // R4 low bits ignored
        {4'b0001, 32'h2000_0000, 32'hA000_0000, 1'b1}, // R6 R7 soft ext
        {4'b0000, 32'h0000_0000, 32'hA000_0000, 1'b0}, // R7 pulse ends
        {4'b0001, 32'h8000_0000, 32'h2000_0000, 1'b0}, // R5 clear bit 31
        {4'b1100, 32'h0000_0000, 32'h3000_0000, 1'b0}, // R3 R8 not re-armed
        {4'b0001, 32'h0000_0000, 32'h3000_0000, 1'b0}, // R5 R6 zero write
        {4'b1010, 32'h0000_0000, 32'h3800_0000, 1'b0}, // R3 button ext
        {4'b0001, 32'h1800_0000, 32'h2000_0000, 1'b0}, // R5 clear 28 27
        {4'b0001, 32'h4000_0000, 32'h6000_0000, 1'b1}, // R7 soft por
        {4'b0001, 32'h4000_0000, 32'h6000_0000, 1'b1}, // R7 back to back
        {4'b0000, 32'h0000_0000, 32'h6000_0000, 1'b0}, // R7 pulse ends
        {4'b1000, 32'h0000_0000, 32'h8000_0000, 1'b0}, // R8 re-armed reload
        {4'b0001, 32'h8000_0000, 32'h0000_0000, 1'b0}, // R5 clear bit 31
        {4'b1000, 32'h0000_0000, 32'h0000_0000, 1'b0}, // R3 warm keeps zero
        {4'b1001, 32'h6000_0000, 32'h0000_0000, 1'b0}, // R9 collision
        {4'b0000, 32'h0000_0000, 32'h0000_0000, 1'b0}, // R9 no late request
        {4'b0001, 32'hFFFF_FFFF, 32'h6000_0000, 1'b1}, // R4 R5 R6 all ones
        {4'b1110, 32'h0000_0000, 32'h9800_0000, 1'b0}  // R8 R2 reload with buttons
    };

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic s, input logic bp, input logic bx,
                        input logic w, input logic [31:0] d);
        sys_rst = s; btn_por_cause = bp; btn_xir_cause = bx;
        wr_en = w; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        sys_rst = 1'b0; btn_por_cause = 1'b0; btn_xir_cause = 1'b0;
        wr_en = 1'b0; wr_data = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 rd in reset", rd_data, 32'h0);
        check("R1 req in reset", {31'b0, rst_req}, 32'h0);
        por_n = 1'b1;
        @(negedge clk);
        check("R1 rd after release", rd_data, 32'h0);
        check("R1 req after release", {31'b0, rst_req}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][68], VEC[i][67], VEC[i][66], VEC[i][65], VEC[i][64:33]);
            check($sformatf("vec%0d rd", i), rd_data, VEC[i][32:1]);
            check($sformatf("vec%0d req", i), {31'b0, rst_req}, {31'b0, VEC[i][0]});
        end

        // R1: power-up reset in the middle of activity clears everything
        step(1'b0, 1'b0, 1'b0, 1'b1, 32'h2000_0000);
        por_n = 1'b0;
        #1;
        check("R1 rd async clear", rd_data, 32'h0);
        check("R1 req async clear", {31'b0, rst_req}, 32'h0);
        @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        // R2: first reset after a new power-up loads the power-on cause
        step(1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
        check("R2 reload after power-up", rd_data, 32'h8000_0000);
        // R3: a second reset keeps the value
        step(1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
        check("R3 second reset keeps", rd_data, 32'h8000_0000);
        // R8: soft ext alone does not re-arm, soft por does
        step(1'b0, 1'b0, 1'b0, 1'b1, 32'hA000_0000);
        check("R8 soft ext write", rd_data, 32'h2000_0000);
        step(1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
        check("R8 no re-arm from bit 29", rd_data, 32'h2000_0000);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                failures++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule